// File: doc/BRIEF.md
# Masked Error and Warning Alarm Aggregator

This block sits next to an encoder-counter core. It turns the core's error and warning event lines into two active-low alarm outputs, one for errors and one for warnings. Each output drives an open-drain pad. A ten-bit enable mask, where 1 means alarm on, and a two-bit disable mask, where 1 means alarm off, pick which events reach the pads. The two masks have opposite polarity. Only one event, the quadrature decode error, is in the error class on the disable mask. On the enable mask, the only error-class event is the externally forced error.

The block reads the pad levels back through synchronisers. This tells it when an alarm line is low, whether another device pulled it low or this block drove it low. It keeps that fact as a sticky status bit. It also keeps a sticky flag when two host interfaces reach the internal register bus in the same cycle. In that case the block grants only the preferred host. A read of either of two status addresses clears the sticky bits. An event that arrives in the same cycle as the clearing read survives the read.

The status word also carries two live bits:
- the synchronised touch-probe input level;
- the interface-select pin level, after a digital filter.

Top module: `alarm_hub`

## Requirements
- R1: After reset, `err_n_o` and `warn_n_o` are 1 and `status_o` is 0, provided `tp_pin_i` and `sel_pin_i` are low.
- R2: `mask_i` bit k set to 1 enables event k. Bit 8 is the external-error status and is error-class. The warning-class bits are:
  - bit 9: select-filter status;
  - bits 7..2: `core_evt_i[5:0]`;
  - bit 1: external-warning status;
  - bit 0: collision status.
  One clock edge after any enabled event of a class is pending, that class's output (`err_n_o` or `warn_n_o`) is 0. It is 1 one edge after none is pending.
- R3: `nmask_i` has inverted polarity, where 0 enables. Bit 1 gates `decode_err_i` onto `err_n_o`. Bit 0 gates `upd_valid_i` onto `warn_n_o`.
- R4: `status_o[3]` (external error) sets on the third clock edge after `err_pin_i` goes low, and stays set after the pin returns high.
- R5: `status_o[2]` (external warning) behaves in the same way for `warn_pin_i`.
- R6: A cycle with `rd_en_i`=1 and `rd_addr_i` equal to `STAT_ADDR_A` or `STAT_ADDR_B` clears `status_o[3:1]` at that edge. A read of any other address leaves them unchanged.
- R7: A set condition in the same cycle as a clearing read leaves the bit set.
- R8: `a_req_i` and `b_req_i` high in the same cycle set `status_o[1]` (collision) at that edge.
- R9: With `share_en_i`=1, `a_ab_wr_i`=1 and `b_ch0_rd_i`=1, simultaneous requests neither set the collision flag nor block either grant.
- R10: During a collision, `gnt_a_o`=1 and `gnt_b_o`=0 in the same cycle. A lone request is granted.
- R11: `status_o[0]` equals `tp_pin_i` two clock edges later.
- R12: `status_o[4]` takes the synchronised `sel_pin_i` level only after it has differed from the current filtered value for `FILT_CYCLES` consecutive edges. Shorter pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mask_i | input | 10 | Enable mask, 1 = alarm on |
| nmask_i | input | 2 | Disable mask, 1 = alarm off |
| core_evt_i | input | 6 | Core warning events, mapped to mask bits 7..2 |
| decode_err_i | input | 1 | Quadrature decode error event |
| upd_valid_i | input | 1 | Update register valid event |
| err_pin_i | input | 1 | Read-back level of the error alarm pad |
| warn_pin_i | input | 1 | Read-back level of the warning alarm pad |
| err_n_o | output | 1 | Error alarm, 0 = pull pad low, 1 = release |
| warn_n_o | output | 1 | Warning alarm, 0 = pull pad low, 1 = release |
| tp_pin_i | input | 1 | Touch-probe input |
| sel_pin_i | input | 1 | Interface-select input, high when open |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | ADDR_W | Register read address |
| a_req_i | input | 1 | Host A bus request |
| a_ab_wr_i | input | 1 | Host A access is an AB write |
| b_req_i | input | 1 | Host B bus request |
| b_ch0_rd_i | input | 1 | Host B access is a channel 0 read |
| share_en_i | input | 1 | Channel-share option |
| gnt_a_o | output | 1 | Host A access granted |
| gnt_b_o | output | 1 | Host B access granted |
| status_o | output | 5 | {select filter, ext error, ext warning, collision, touch-probe} |

## Verification
A wrong sticky bit shows up twice at the ports. It shows in `status_o` on the next sample. If its mask bit is on, it also shows as a stuck or missing alarm one edge later. A stuck error bit with mask bit 8 on latches the pad low through the read-back loop. A dropped clear shows up in the status word after the read.

The filter count is observable only at the `FILT_CYCLES` boundary. The bench therefore checks both a pulse shorter than the window and a level held past it.

// File: rtl/alarm_hub.sv
module alarm_hub #(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] STAT_ADDR_A = 7'h20,
  parameter logic [ADDR_W-1:0] STAT_ADDR_B = 7'h21,
  parameter int FILT_CYCLES = 625
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [9:0]        mask_i,
  input  logic [1:0]        nmask_i,
  input  logic [5:0]        core_evt_i,
  input  logic              decode_err_i,
  input  logic              upd_valid_i,
  input  logic              err_pin_i,
  input  logic              warn_pin_i,
  output logic              err_n_o,
  output logic              warn_n_o,
  input  logic              tp_pin_i,
  input  logic              sel_pin_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              a_req_i,
  input  logic              a_ab_wr_i,
  input  logic              b_req_i,
  input  logic              b_ch0_rd_i,
  input  logic              share_en_i,
  output logic              gnt_a_o,
  output logic              gnt_b_o,
  output logic [4:0]        status_o
);
  localparam int CNT_W = $clog2(FILT_CYCLES + 1);

  logic [1:0] err_sync, warn_sync, tp_sync, sel_sync;
  logic       ext_err_q, ext_warn_q, coll_q, ssi_q;
  logic [CNT_W-1:0] filt_cnt;

  wire both_req   = a_req_i && b_req_i;
  wire shared_ok  = share_en_i && a_ab_wr_i && b_ch0_rd_i;
  wire collide    = both_req && !shared_ok;
  wire stat_read  = rd_en_i && (rd_addr_i == STAT_ADDR_A || rd_addr_i == STAT_ADDR_B);
  wire err_seen   = !err_sync[1];
  wire warn_seen  = !warn_sync[1];

  assign gnt_a_o = a_req_i;
  assign gnt_b_o = b_req_i && !collide;

  wire [9:0] evt_vec = {ssi_q, ext_err_q, core_evt_i, ext_warn_q, coll_q};
  wire [9:0] warn_sel = 10'h2FF;

  wire err_pend  = (mask_i[8] && ext_err_q) || (!nmask_i[1] && decode_err_i);
  wire warn_pend = |(evt_vec & mask_i & warn_sel) || (!nmask_i[0] && upd_valid_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_sync  <= 2'b11;
      warn_sync <= 2'b11;
      tp_sync   <= 2'b00;
      sel_sync  <= 2'b00;
    end else begin
      err_sync  <= {err_sync[0], err_pin_i};
      warn_sync <= {warn_sync[0], warn_pin_i};
      tp_sync   <= {tp_sync[0], tp_pin_i};
      sel_sync  <= {sel_sync[0], sel_pin_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_err_q  <= 1'b0;
      ext_warn_q <= 1'b0;
      coll_q     <= 1'b0;
    end else begin
      ext_err_q  <= err_seen  || (ext_err_q  && !stat_read);
      ext_warn_q <= warn_seen || (ext_warn_q && !stat_read);
      coll_q     <= collide   || (coll_q     && !stat_read);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ssi_q    <= 1'b0;
      filt_cnt <= '0;
    end else if (sel_sync[1] == ssi_q) begin
      filt_cnt <= '0;
    end else if (filt_cnt == CNT_W'(FILT_CYCLES - 1)) begin
      ssi_q    <= sel_sync[1];
      filt_cnt <= '0;
    end else begin
      filt_cnt <= filt_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_n_o  <= 1'b1;
      warn_n_o <= 1'b1;
    end else begin
      err_n_o  <= !err_pend;
      warn_n_o <= !warn_pend;
    end
  end

  assign status_o = {ssi_q, ext_err_q, ext_warn_q, coll_q, tp_sync[1]};

  p_err_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i[8] && ext_err_q) |=> !err_n_o);
  p_nmask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmask_i[0] && upd_valid_i) |=> !warn_n_o);
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_err_q && !stat_read) |=> ext_err_q);
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_read && warn_sync[1]) |=> !ext_warn_q);
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_read && collide) |=> coll_q);
  p_coll_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (a_req_i && b_req_i && !(share_en_i && a_ab_wr_i && b_ch0_rd_i)) |=> status_o[1]);
  p_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(gnt_a_o && gnt_b_o && !(share_en_i && a_ab_wr_i && b_ch0_rd_i)));
  p_filt_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_cnt == '0 && sel_sync[1] != ssi_q) |=> $stable(ssi_q) || FILT_CYCLES == 1);
endmodule

// File: tb/alarm_hub_tb_top.sv
module alarm_hub_tb_top;
  localparam int FILT = 625;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic [9:0] mask = 0;
  logic [1:0] nmask = 2'b11;
  logic [5:0] core = 0;
  logic dec = 0, upd = 0, pull_err_n = 1, pull_warn_n = 1;
  logic tp = 0, sel = 0, rd = 0, a_req = 0, a_ab = 0, b_req = 0, b_ch0 = 0, share = 0;
  logic [6:0] addr = 0;
  logic err_n, warn_n, gnt_a, gnt_b;
  logic [4:0] st;
  wire err_pin  = err_n & pull_err_n;
  wire warn_pin = warn_n & pull_warn_n;
  int checks = 0, fails = 0;
  bit done = 0;

  alarm_hub dut_i (
    .clk(clk), .rst_n(rst_n), .mask_i(mask), .nmask_i(nmask), .core_evt_i(core),
    .decode_err_i(dec), .upd_valid_i(upd), .err_pin_i(err_pin), .warn_pin_i(warn_pin),
    .err_n_o(err_n), .warn_n_o(warn_n), .tp_pin_i(tp), .sel_pin_i(sel),
    .rd_en_i(rd), .rd_addr_i(addr), .a_req_i(a_req), .a_ab_wr_i(a_ab), .b_req_i(b_req),
    .b_ch0_rd_i(b_ch0), .share_en_i(share), .gnt_a_o(gnt_a), .gnt_b_o(gnt_b), .status_o(st));

  // {mask, nmask, core, dec, upd, exp_err_n, exp_warn_n}
  localparam logic [21:0] VEC [10] = '{
    {10'h000, 2'b11, 6'h00, 1'b1, 1'b1, 1'b1, 1'b1},
    {10'h000, 2'b00, 6'h00, 1'b1, 1'b0, 1'b0, 1'b1},
    {10'h000, 2'b00, 6'h00, 1'b0, 1'b1, 1'b1, 1'b0},
    {10'h000, 2'b10, 6'h00, 1'b1, 1'b1, 1'b1, 1'b0},
    {10'h080, 2'b11, 6'h20, 1'b0, 1'b0, 1'b1, 1'b0},
    {10'h004, 2'b11, 6'h01, 1'b0, 1'b0, 1'b1, 1'b0},
    {10'h004, 2'b11, 6'h20, 1'b0, 1'b0, 1'b1, 1'b1},
    {10'h0FC, 2'b11, 6'h00, 1'b1, 1'b1, 1'b1, 1'b1},
    {10'h0F8, 2'b11, 6'h02, 1'b0, 1'b0, 1'b1, 1'b0},
    {10'h2FD, 2'b11, 6'h00, 1'b0, 1'b0, 1'b1, 1'b1}};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_read(logic [6:0] a);
    addr = a; rd = 1; step(1); rd = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    chk("R1 err_n", err_n, 1); chk("R1 warn_n", warn_n, 1); chk("R1 status", st, 0);

    foreach (VEC[i]) begin
      {mask, nmask, core, dec, upd} = VEC[i][21:2];
      step(1);
      chk($sformatf("R2/R3 vec%0d err_n", i), err_n, VEC[i][1]);
      chk($sformatf("R2/R3 vec%0d warn_n", i), warn_n, VEC[i][0]);
      mask = 0; nmask = 2'b11; core = 0; dec = 0; upd = 0;
      step(5);
      clear_read(7'h20);
    end
    step(2);
    chk("R6 status after vectors", st[3:1], 0);

    // R4 external error, mask off
    pull_err_n = 0; step(2); chk("R4 not yet", st[3], 0);
    step(1); chk("R4 set", st[3], 1);
    pull_err_n = 1; step(4); chk("R4 sticky", st[3], 1);
    chk("R2 err masked off", err_n, 1);
    clear_read(7'h22); chk("R6 other addr keeps", st[3], 1);
    clear_read(7'h21); chk("R6 addr B clears", st[3], 0);

    // R2 bit 8 drives error pad
    mask = 10'h100; pull_err_n = 0; step(1); pull_err_n = 1; step(2);
    chk("R4 pulse set", st[3], 1);
    step(1); chk("R2 ext err alarm", err_n, 0);
    mask = 0; step(1); chk("R2 released", err_n, 1);
    step(4); clear_read(7'h20); chk("R6 clear err", st[3], 0);

    // R5 external warning
    pull_warn_n = 0; step(3); chk("R5 set", st[2], 1);
    pull_warn_n = 1; step(3); chk("R5 sticky", st[2], 1);
    clear_read(7'h20); chk("R6 clear warn", st[2], 0);

    // R8/R10 collision
    a_req = 1; b_req = 1; #2;
    chk("R10 gnt_a", gnt_a, 1); chk("R10 gnt_b", gnt_b, 0);
    step(1); a_req = 0; b_req = 1; #2;
    chk("R8 coll set", st[1], 1); chk("R10 lone b", gnt_b, 1);
    b_req = 0; clear_read(7'h20); chk("R6 coll clear", st[1], 0);

    // R7 collision in same cycle as clearing read
    a_req = 1; b_req = 1; addr = 7'h21; rd = 1; step(1);
    rd = 0; a_req = 0; b_req = 0;
    chk("R7 set wins", st[1], 1);
    clear_read(7'h21); chk("R7 later clear", st[1], 0);

    // R9 share exception
    share = 1; a_ab = 1; b_ch0 = 1; a_req = 1; b_req = 1; #2;
    chk("R9 both granted", {gnt_a, gnt_b}, 2'b11);
    step(1); a_req = 0; b_req = 0;
    chk("R9 no coll", st[1], 0);
    share = 0; a_ab = 0; b_ch0 = 0;

    // R11 touch probe
    tp = 1; step(1); chk("R11 lag", st[0], 0);
    step(1); chk("R11 high", st[0], 1);
    tp = 0; step(2); chk("R11 low", st[0], 0);

    // R12 filter: short pulse ignored, long level taken
    sel = 1; step(300); sel = 0; step(FILT + 10);
    chk("R12 glitch ignored", st[4], 0);
    sel = 1; step(FILT - 10); chk("R12 before window", st[4], 0);
    step(15); chk("R12 taken", st[4], 1);
    mask = 10'h200; step(1); chk("R2 ssi warn", warn_n, 0);
    mask = 0; sel = 0; step(FILT + 5); chk("R12 back low", st[4], 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule